// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is the register interface between a host bus and a local keyboard-controller CPU, in the style of the classic PC keyboard controller. The host sees two byte-wide ports, a data port and a command/status port, chosen by host address bit 2. Any host write lands in one shared input register. The block tags that byte as a command or as data from the port used, so the local CPU can tell them apart.

In the other direction, the local CPU writes an output byte. This marks the output buffer as full and can raise a keyboard interrupt. A host read of the data port can clear the flag and the interrupt in hardware (auto-clear), or leave both for local software to clear with dedicated strobes. A separate mouse interrupt line is set and cleared by local strobes.

Two small state machines carry the flags. The input machine has states `IN_EMPTY` and `IN_FULL`. A host write takes `IN_EMPTY`→`IN_FULL` or `IN_FULL`→`IN_FULL`, and the new byte replaces the old one. A local read takes `IN_FULL`→`IN_EMPTY`. The output machine has states `OUT_EMPTY` and `OUT_FULL`. A local write takes either state to `OUT_FULL`. A clearing event takes `OUT_FULL`→`OUT_EMPTY`. A clearing event is either an auto-cleared host data read or the local clear strobe. A local write in the same cycle takes priority over any clearing event.

Top module: `kbd_host_mailbox`

## Requirements
- R1: After reset the status byte reads 0x00, both interrupt outputs are low, auto-clear is enabled and the keyboard interrupt enable is off.
- R2: A host write with `host_port_sel`=0 (data port) stores the byte in the input register and, from the next cycle, sets input-full (status bit 1) and clears the command flag (status bit 3).
- R3: A host write with `host_port_sel`=1 (command port) stores the byte, sets input-full and sets the command flag to 1.
- R4: A host read with `host_port_sel`=1 returns the status byte in the same cycle: bit 0 output-full, bit 1 input-full, bit 3 command flag, other bits 0. The read changes no state.
- R5: A local output write sets output-full (status bit 0) from the next cycle, and a host data-port read then returns that byte.
- R6: With auto-clear enabled, a host data-port read clears output-full and the keyboard interrupt from the next cycle.
- R7: With auto-clear disabled, a host data-port read leaves output-full and the keyboard interrupt set. `cpu_obf_clr` and `cpu_kirq_clr` each clear their own flag.
- R8: A local input read (`cpu_in_rd`) clears input-full from the next cycle and leaves the command flag unchanged.
- R9: `cpu_mirq_set` raises `mouse_irq` and `cpu_mirq_clr` lowers it. Set wins when both come in the same cycle.
- R10: When a local output write and an auto-clearing host data read come in the same cycle, output-full and the keyboard interrupt remain high.
- R11: When a host write and a local input read come in the same cycle, input-full remains set and the new byte is held.
- R12: The keyboard interrupt rises on a local output write only while the interrupt enable is 1. Output-full is set either way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_port_sel | input | 1 | Host address bit 2: 0 data port, 1 command/status port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (status or output data) |
| cpu_in_rd | input | 1 | Local read of the input register |
| cpu_in_data | output | 8 | Input register contents |
| cpu_status | output | 8 | Status byte as seen locally |
| cpu_out_wr | input | 1 | Local write of the output register |
| cpu_out_wdata | input | 8 | Local output byte |
| cpu_obf_clr | input | 1 | Local clear of output-full |
| cpu_kirq_clr | input | 1 | Local clear of keyboard interrupt |
| cpu_mirq_set | input | 1 | Local raise of mouse interrupt |
| cpu_mirq_clr | input | 1 | Local clear of mouse interrupt |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_autoclr | input | 1 | Auto-clear enable value for `cfg_wr` |
| cfg_kirq_en | input | 1 | Keyboard interrupt enable value for `cfg_wr` |
| kbd_irq | output | 1 | Keyboard interrupt |
| mouse_irq | output | 1 | Mouse interrupt |

## Verification
On every cycle, the assertions check the flag transitions that follow one strobe. Input-full and the command tag follow a host write. Output-full follows a local write. Auto-clear drops both output flags. A disabled auto-clear leaves output-full alone. The mouse line follows its set strobe. The read data returned to the host and the bit layout of the status byte can be shown only by the bench's scenarios. The same holds for a status read leaving state untouched and for the cycles where several strobes collide.

// File: rtl/kbd_mbx_pkg.sv
package kbd_mbx_pkg;
    localparam int BYTE_W = 8;

    localparam int ST_OBF = 0;
    localparam int ST_IBF = 1;
    localparam int ST_CMD = 3;

    typedef enum logic {
        IN_EMPTY = 1'b0,
        IN_FULL  = 1'b1
    } in_state_e;

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } out_state_e;
endpackage

// File: rtl/kbd_in_fsm.sv
module kbd_in_fsm
    import kbd_mbx_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_wr,
    input  logic         host_port_sel,
    input  logic [W-1:0] host_wdata,
    input  logic         cpu_in_rd,
    output logic [W-1:0] in_data,
    output logic         ibf,
    output logic         cmd_flag
);
    in_state_e    state_q, state_d;
    logic [W-1:0] data_q;
    logic         cmd_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IN_EMPTY: if (host_wr) state_d = IN_FULL;
            IN_FULL:  if (host_wr) state_d = IN_FULL;
                      else if (cpu_in_rd) state_d = IN_EMPTY;
            default:  state_d = IN_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IN_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            cmd_q  <= 1'b0;
        end else if (host_wr) begin
            data_q <= host_wdata;
            cmd_q  <= host_port_sel;
        end
    end

    assign in_data  = data_q;
    assign ibf      = (state_q == IN_FULL);
    assign cmd_flag = cmd_q;

    // R2 R3 R11
    ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> ibf);
    // R2 R3
    cmd_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (cmd_flag == $past(host_port_sel)));
    // R8
    ibf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_in_rd && !host_wr) |=> (!ibf && $stable(cmd_flag)));
endmodule

// File: rtl/kbd_out_fsm.sv
module kbd_out_fsm
    import kbd_mbx_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cpu_out_wr,
    input  logic [W-1:0] cpu_out_wdata,
    input  logic         host_data_rd,
    input  logic         autoclr,
    input  logic         kirq_en,
    input  logic         cpu_obf_clr,
    input  logic         cpu_kirq_clr,
    output logic [W-1:0] out_data,
    output logic         obf,
    output logic         kirq
);
    out_state_e   state_q, state_d;
    logic [W-1:0] data_q;
    logic         kirq_q, kirq_d;
    logic         hw_clear;

    assign hw_clear = host_data_rd && autoclr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_EMPTY: if (cpu_out_wr) state_d = OUT_FULL;
            OUT_FULL:  if (cpu_out_wr) state_d = OUT_FULL;
                       else if (hw_clear || cpu_obf_clr) state_d = OUT_EMPTY;
            default:   state_d = OUT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OUT_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        kirq_d = kirq_q;
        if (cpu_out_wr && kirq_en)            kirq_d = 1'b1;
        else if (hw_clear || cpu_kirq_clr)    kirq_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            kirq_q <= 1'b0;
        end else begin
            kirq_q <= kirq_d;
            if (cpu_out_wr) data_q <= cpu_out_wdata;
        end
    end

    assign out_data = data_q;
    assign obf      = (state_q == OUT_FULL);
    assign kirq     = kirq_q;

    // R5 R10
    obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_out_wr |=> obf);
    // R6
    autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_data_rd && autoclr && !cpu_out_wr) |=> (!obf && !kirq));
    // R7
    no_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_data_rd && !autoclr && !cpu_out_wr && !cpu_obf_clr) |=> (obf == $past(obf)));
    // R12
    kirq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!kirq && !(cpu_out_wr && kirq_en)) |=> !kirq);
endmodule

// File: rtl/kbd_host_mailbox.sv
module kbd_host_mailbox
    import kbd_mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic        host_port_sel,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic        cpu_in_rd,
    output logic [7:0]  cpu_in_data,
    output logic [7:0]  cpu_status,
    input  logic        cpu_out_wr,
    input  logic [7:0]  cpu_out_wdata,
    input  logic        cpu_obf_clr,
    input  logic        cpu_kirq_clr,
    input  logic        cpu_mirq_set,
    input  logic        cpu_mirq_clr,
    input  logic        cfg_wr,
    input  logic        cfg_autoclr,
    input  logic        cfg_kirq_en,
    output logic        kbd_irq,
    output logic        mouse_irq
);
    logic [BYTE_W-1:0] out_data;
    logic [BYTE_W-1:0] status;
    logic              ibf, obf, cmd_flag;
    logic              autoclr_q, kirq_en_q, mirq_q;
    logic              host_data_rd;

    assign host_data_rd = host_rd && !host_port_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            autoclr_q <= 1'b1;
            kirq_en_q <= 1'b0;
        end else if (cfg_wr) begin
            autoclr_q <= cfg_autoclr;
            kirq_en_q <= cfg_kirq_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)            mirq_q <= 1'b0;
        else if (cpu_mirq_set) mirq_q <= 1'b1;
        else if (cpu_mirq_clr) mirq_q <= 1'b0;
    end

    kbd_in_fsm #(.W(BYTE_W)) u_in (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr       (host_wr),
        .host_port_sel (host_port_sel),
        .host_wdata    (host_wdata),
        .cpu_in_rd     (cpu_in_rd),
        .in_data       (cpu_in_data),
        .ibf           (ibf),
        .cmd_flag      (cmd_flag)
    );

    kbd_out_fsm #(.W(BYTE_W)) u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_out_wr    (cpu_out_wr),
        .cpu_out_wdata (cpu_out_wdata),
        .host_data_rd  (host_data_rd),
        .autoclr       (autoclr_q),
        .kirq_en       (kirq_en_q),
        .cpu_obf_clr   (cpu_obf_clr),
        .cpu_kirq_clr  (cpu_kirq_clr),
        .out_data      (out_data),
        .obf           (obf),
        .kirq          (kbd_irq)
    );

    always_comb begin
        status         = '0;
        status[ST_OBF] = obf;
        status[ST_IBF] = ibf;
        status[ST_CMD] = cmd_flag;
    end

    assign host_rdata = host_port_sel ? status : out_data;
    assign cpu_status = status;
    assign mouse_irq  = mirq_q;

    // R9
    mirq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_mirq_set |=> mouse_irq);
    // R9
    mirq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mirq_clr && !cpu_mirq_set) |=> !mouse_irq);
endmodule

// File: tb/kbd_host_mailbox_tb.sv
module kbd_host_mailbox_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 0, host_rd = 0, host_port_sel = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic       cpu_in_rd = 0;
    logic [7:0] cpu_in_data, cpu_status;
    logic       cpu_out_wr = 0;
    logic [7:0] cpu_out_wdata = 0;
    logic       cpu_obf_clr = 0, cpu_kirq_clr = 0, cpu_mirq_set = 0, cpu_mirq_clr = 0;
    logic       cfg_wr = 0, cfg_autoclr = 0, cfg_kirq_en = 0;
    logic       kbd_irq, mouse_irq;
    int         checks = 0;
    int         errors = 0;
    logic [7:0] rd;

    always #2 clk = ~clk;

    kbd_host_mailbox u_dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        host_wr = 0; host_rd = 0; cpu_in_rd = 0; cpu_out_wr = 0;
        cpu_obf_clr = 0; cpu_kirq_clr = 0; cpu_mirq_set = 0; cpu_mirq_clr = 0; cfg_wr = 0;
    endtask

    task automatic host_write(input logic port, input logic [7:0] b);
        host_wr = 1; host_port_sel = port; host_wdata = b;
        @(negedge clk); idle();
    endtask

    task automatic host_read(input logic port, output logic [7:0] b);
        host_rd = 1; host_port_sel = port;
        #1 b = host_rdata;
        @(negedge clk); idle();
    endtask

    task automatic out_write(input logic [7:0] b);
        cpu_out_wr = 1; cpu_out_wdata = b;
        @(negedge clk); idle();
    endtask

    task automatic set_cfg(input logic ac, input logic en);
        cfg_wr = 1; cfg_autoclr = ac; cfg_kirq_en = en;
        @(negedge clk); idle();
    endtask

    task automatic t_reset();
        chk("R1 status", cpu_status, 8'h00);
        chk("R1 irqs", {6'b0, kbd_irq, mouse_irq}, 8'h00);
        out_write(8'h11);
        host_read(1'b0, rd);
        chk("R1 autoclr default", cpu_status, 8'h00);
        chk("R1 kirq_en default", {7'b0, kbd_irq}, 8'h00);
    endtask

    task automatic t_host_writes();
        host_write(1'b0, 8'hA5);
        chk("R2 data", cpu_in_data, 8'hA5);
        chk("R2 status", cpu_status, 8'h02);
        host_write(1'b1, 8'hD4);
        chk("R3 data", cpu_in_data, 8'hD4);
        chk("R3 status", cpu_status, 8'h0A);
        host_read(1'b1, rd);
        chk("R4 status read", rd, 8'h0A);
        chk("R4 unchanged", cpu_status, 8'h0A);
        chk("R4 data unchanged", cpu_in_data, 8'hD4);
        cpu_in_rd = 1; @(negedge clk); idle();
        chk("R8 ibf clear keep cmd", cpu_status, 8'h08);
    endtask

    task automatic t_collide_in();
        cpu_in_rd = 1; host_wr = 1; host_port_sel = 0; host_wdata = 8'h3C;
        @(negedge clk); idle();
        chk("R11 ibf held", cpu_status, 8'h02);
        chk("R11 byte", cpu_in_data, 8'h3C);
        cpu_in_rd = 1; @(negedge clk); idle();
    endtask

    task automatic t_autoclr();
        set_cfg(1'b1, 1'b1);
        out_write(8'h5A);
        chk("R5 obf", cpu_status, 8'h01);
        chk("R12 kirq on", {7'b0, kbd_irq}, 8'h01);
        host_read(1'b0, rd);
        chk("R5 read byte", rd, 8'h5A);
        chk("R6 obf cleared", cpu_status, 8'h00);
        chk("R6 kirq cleared", {7'b0, kbd_irq}, 8'h00);
        out_write(8'h77);
        host_rd = 1; host_port_sel = 0; cpu_out_wr = 1; cpu_out_wdata = 8'h78;
        @(negedge clk); idle();
        chk("R10 obf stays", cpu_status, 8'h01);
        chk("R10 kirq stays", {7'b0, kbd_irq}, 8'h01);
        host_read(1'b0, rd);
        chk("R10 new byte", rd, 8'h78);
    endtask

    task automatic t_manual();
        set_cfg(1'b0, 1'b1);
        out_write(8'hC3);
        host_read(1'b0, rd);
        chk("R7 read byte", rd, 8'hC3);
        chk("R7 obf kept", cpu_status, 8'h01);
        chk("R7 kirq kept", {7'b0, kbd_irq}, 8'h01);
        cpu_obf_clr = 1; @(negedge clk); idle();
        chk("R7 obf clr", cpu_status, 8'h00);
        chk("R7 kirq still", {7'b0, kbd_irq}, 8'h01);
        cpu_kirq_clr = 1; @(negedge clk); idle();
        chk("R7 kirq clr", {7'b0, kbd_irq}, 8'h00);
        set_cfg(1'b0, 1'b0);
        out_write(8'h01);
        chk("R12 obf set no irq", cpu_status, 8'h01);
        chk("R12 kirq off", {7'b0, kbd_irq}, 8'h00);
    endtask

    task automatic t_mouse();
        cpu_mirq_set = 1; @(negedge clk); idle();
        chk("R9 set", {7'b0, mouse_irq}, 8'h01);
        cpu_mirq_set = 1; cpu_mirq_clr = 1; @(negedge clk); idle();
        chk("R9 set wins", {7'b0, mouse_irq}, 8'h01);
        cpu_mirq_clr = 1; @(negedge clk); idle();
        chk("R9 clear", {7'b0, mouse_irq}, 8'h00);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                @(negedge clk);
                t_reset();
                t_host_writes();
                t_collide_in();
                t_autoclr();
                t_manual();
                t_mouse();
            end
            begin
                repeat (5000) @(negedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule